// File: doc/BRIEF.md
# Clock Register Snapshot Transfer Control

This block holds the host-visible copy of the eight time-of-day registers (addresses 00h to 07h). The counting logic keeps its own copy, which advances on its own. Each time the counting logic signals an increment, the block copies the whole internal time vector into the host copy in one cycle, so the host never sees a mix of old and new fields. A register pointer covers a 20-location map (00h to 13h). The protocol front end drives this pointer with load, read, write and bus-stop strobes. Host reads return bytes from the host copy.

Two conditions block the copy. The first is a read hold. It starts when the host reads a clock address, and it ends on a bus stop or when the pointer moves to 08h or above. A copy requested during the hold is kept pending and is carried out on the first cycle after the hold ends, so no increment is lost. The second is a halt flag. A power-fail indication sets it, and it freezes the host copy at the time of the outage. The host clears it by writing zero to the flag. A host write to a clock address goes into the host copy and is passed to the counting logic in the same cycle.

Top module: `clk_snap_xfer`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 00h, the halt flag and read hold are 0, and all eight host-copy bytes read as 00h.
- R2: Each read or write strobe advances the pointer by one, and the pointer wraps from 13h (19) to 00h. A pointer load sets the pointer to the given value, and a value above 19 loads 00h. A pointer load does not advance the pointer.
- R3: When neither the hold nor the halt flag is active, an update tick copies all eight bytes of the internal time vector (byte k at bits 8k+7:8k) into the host copy at the same clock edge.
- R4: A read strobe at a clock address (00h to 07h) starts the read hold. While the hold is active, update ticks leave the host copy unchanged.
- R5: A bus stop ends the read hold at the next edge. A tick that arrived during the hold is then carried out on the first cycle after the hold ends, using the internal time vector present in that cycle.
- R6: The read hold also ends when the pointer moves to an address from 08h to 13h, for example after a sequential read of 07h. The pending copy then follows on the next cycle.
- R7: A power-fail indication sets the halt flag at the next edge. While the flag is set, ticks do not change the host copy. Reading address 0Ch returns the halt flag in bit 6, with all other bits 0.
- R8: A write to address 0Ch with bit 6 clear clears the halt flag, unless power-fail is asserted in the same cycle. A tick that arrived during the halt is then carried out on the next cycle.
- R9: A write at a clock address stores the data in that host-copy byte. In the same cycle it raises the internal write strobe, with the byte index and data. A write to address 00h always stores and forwards 00h.
- R10: A read of a clock address returns the host-copy byte at the pointer. Addresses 08h to 13h, other than 0Ch, return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_load_i | input | 1 | Load the pointer with ptr_val_i |
| ptr_val_i | input | 5 | Pointer load value |
| rd_en_i | input | 1 | Byte read strobe at the current pointer |
| wr_en_i | input | 1 | Byte write strobe at the current pointer |
| wr_data_i | input | 8 | Write data |
| stop_i | input | 1 | Bus stop condition |
| pwr_fail_i | input | 1 | Power-fail indication |
| upd_tick_i | input | 1 | Internal copy has incremented |
| int_time_i | input | 64 | Internal time vector, byte k = address k |
| rd_data_o | output | 8 | Read data at the current pointer |
| ptr_o | output | 5 | Current pointer |
| halt_o | output | 1 | Halt flag |
| hold_o | output | 1 | Read hold active |
| int_wr_en_o | output | 1 | Write strobe to the internal copy |
| int_wr_addr_o | output | 3 | Clock byte index for the internal write |
| int_wr_data_o | output | 8 | Data for the internal write |

## Verification
The hardest case to reach is a copy that is blocked while the internal time keeps moving, followed by the pending copy landing exactly one cycle after the release. The host copy can only be observed through the read port, and a read of a clock address itself starts a hold. The bench therefore observes the copy by loading the pointer without strobing a read: the read data follows the pointer directly, and the hold is left as it was. For every starting clock address, the bench starts a hold, ticks in a new time vector, checks that all eight bytes still hold the old one, and then releases the hold. It alternates between a bus stop and a sequential read that walks the pointer past 07h.

// File: rtl/snap_pkg.sv
// Package: shared sizing defaults for the clock snapshot transfer block.
// Assumes a byte-wide register map with the clock bytes at the bottom.
package snap_pkg;
    localparam int ADDR_W_D    = 5;
    localparam int BYTE_W_D    = 8;
    localparam int N_CLK_D     = 8;
    localparam int LAST_ADDR_D = 19;
    localparam int HALT_ADDR_D = 12;
    localparam int HALT_BIT_D  = 6;
endpackage

// File: rtl/snap_ptr.sv
// Module: register pointer. It loads on request and advances after each byte
// access, wrapping from LAST_ADDR to zero.
// Assumes load and access strobes are not raised together; load wins if they are.
module snap_ptr #(
    parameter int ADDR_W    = 5,
    parameter int LAST_ADDR = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] ptr_q_o,
    output logic [ADDR_W-1:0] ptr_nxt_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

    logic [ADDR_W-1:0] ptr_q;

    // Next pointer: load (clamped to the map), step with wrap, or hold.
    always_comb begin
        if (load_i)
            ptr_nxt_o = (load_val_i > LAST) ? '0 : load_val_i;
        else if (step_i)
            ptr_nxt_o = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        else
            ptr_nxt_o = ptr_q;
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_nxt_o;
    end

    assign ptr_q_o = ptr_q;

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ptr_q <= LAST); // R2
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && ptr_q == LAST) |=> ptr_q == '0); // R2
endmodule

// File: rtl/snap_xfer_ctrl.sv
// Module: transfer control. It tracks the read hold, the power-fail halt flag
// and the pending copy, and decides in which cycle the host copy is refreshed.
// Assumes ptr_nxt_i is the pointer value after the current edge.
module snap_xfer_ctrl #(
    parameter int ADDR_W    = 5,
    parameter int BYTE_W    = 8,
    parameter int N_CLK     = 8,
    parameter int HALT_ADDR = 12,
    parameter int HALT_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ptr_q_i,
    input  logic [ADDR_W-1:0] ptr_nxt_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              stop_i,
    input  logic              pwr_fail_i,
    input  logic              tick_i,
    output logic              hold_o,
    output logic              halt_o,
    output logic              xfer_go_o
);
    localparam logic [ADDR_W-1:0] CLK_END = ADDR_W'(N_CLK);
    localparam logic [ADDR_W-1:0] HADDR   = ADDR_W'(HALT_ADDR);

    logic hold_q, halt_q, pend_q;
    logic rd_clk, nxt_clk, blocked, want;

    assign rd_clk  = rd_en_i && (ptr_q_i < CLK_END);
    assign nxt_clk = ptr_nxt_i < CLK_END;
    assign blocked = halt_q || hold_q || rd_clk;
    assign want    = tick_i || pend_q;

    // Copy request is granted only when nothing blocks it.
    assign xfer_go_o = want && !blocked;

    // Read hold: started by a clock-address read, ended by stop or leaving the clock range.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= !stop_i && (hold_q || rd_clk) && nxt_clk;
    end

    // Pending copy: remembers a tick that arrived while blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= want && blocked;
    end

    // Halt flag: set by power fail, otherwise written through its map location.
    always_ff @(posedge clk) begin
        if (!rst_n)                               halt_q <= 1'b0;
        else if (pwr_fail_i)                      halt_q <= 1'b1;
        else if (wr_en_i && ptr_q_i == HADDR)     halt_q <= wr_data_i[HALT_BIT];
    end

    assign hold_o = hold_q;
    assign halt_o = halt_q;

    AST_PF_SETS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> halt_q); // R7
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !hold_q); // R5
    AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !nxt_clk |=> !hold_q); // R6
    AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !halt_q && !hold_q && !rd_clk) |=> !pend_q); // R5
endmodule

// File: rtl/snap_user_bank.sv
// Module: host-visible copy of the clock bytes. It accepts a whole-vector copy
// or a single host byte write; the host write wins for its byte.
// Assumes byte 0 is the sub-second field, which host writes force to zero.
module snap_user_bank #(
    parameter int ADDR_W = 5,
    parameter int BYTE_W = 8,
    parameter int N_CLK  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    xfer_go_i,
    input  logic [N_CLK*BYTE_W-1:0] int_time_i,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       ptr_q_i,
    input  logic [BYTE_W-1:0]       wr_data_i,
    output logic [N_CLK*BYTE_W-1:0] user_o
);
    localparam logic [ADDR_W-1:0] CLK_END = ADDR_W'(N_CLK);

    logic wr_hit;
    assign wr_hit = wr_en_i && (ptr_q_i < CLK_END);

    for (genvar g = 0; g < N_CLK; g++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;
        logic              sel;
        assign sel = wr_hit && (ptr_q_i == ADDR_W'(g));

        // One host-copy byte: host write first, then bulk copy.
        always_ff @(posedge clk) begin
            if (!rst_n)         byte_q <= '0;
            else if (sel)       byte_q <= (g == 0) ? '0 : wr_data_i;
            else if (xfer_go_i) byte_q <= int_time_i[g*BYTE_W +: BYTE_W];
        end

        assign user_o[g*BYTE_W +: BYTE_W] = byte_q;
    end

    AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_go_i && !wr_hit) |=> user_o == $past(int_time_i)); // R3
    AST_SUBSEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ptr_q_i == '0 && !xfer_go_i) |=> user_o[BYTE_W-1:0] == '0); // R9
endmodule

// File: rtl/clk_snap_xfer.sv
// Module: top of the clock snapshot transfer block. It ties together the pointer,
// the transfer control and the host copy, and drives read data and internal writes.
// Assumes one strobe (load, read or write) per cycle from the protocol front end.
module clk_snap_xfer #(
    parameter int ADDR_W    = snap_pkg::ADDR_W_D,
    parameter int BYTE_W    = snap_pkg::BYTE_W_D,
    parameter int N_CLK     = snap_pkg::N_CLK_D,
    parameter int LAST_ADDR = snap_pkg::LAST_ADDR_D,
    parameter int HALT_ADDR = snap_pkg::HALT_ADDR_D,
    parameter int HALT_BIT  = snap_pkg::HALT_BIT_D,
    localparam int SEL_W    = $clog2(N_CLK),
    localparam int VEC_W    = N_CLK * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load_i,
    input  logic [ADDR_W-1:0] ptr_val_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              stop_i,
    input  logic              pwr_fail_i,
    input  logic              upd_tick_i,
    input  logic [VEC_W-1:0]  int_time_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              halt_o,
    output logic              hold_o,
    output logic              int_wr_en_o,
    output logic [SEL_W-1:0]  int_wr_addr_o,
    output logic [BYTE_W-1:0] int_wr_data_o
);
    localparam logic [ADDR_W-1:0] CLK_END = ADDR_W'(N_CLK);
    localparam logic [ADDR_W-1:0] HADDR   = ADDR_W'(HALT_ADDR);

    logic [ADDR_W-1:0] ptr_q, ptr_nxt;
    logic              xfer_go, hold, halt;
    logic [VEC_W-1:0]  user;
    logic              ptr_in_clk;

    snap_ptr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load_i(ptr_load_i), .load_val_i(ptr_val_i),
        .step_i(rd_en_i || wr_en_i), .ptr_q_o(ptr_q), .ptr_nxt_o(ptr_nxt)
    );

    snap_xfer_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_CLK(N_CLK),
                     .HALT_ADDR(HALT_ADDR), .HALT_BIT(HALT_BIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ptr_q_i(ptr_q), .ptr_nxt_i(ptr_nxt),
        .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .stop_i(stop_i), .pwr_fail_i(pwr_fail_i), .tick_i(upd_tick_i),
        .hold_o(hold), .halt_o(halt), .xfer_go_o(xfer_go)
    );

    snap_user_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_CLK(N_CLK)) u_bank (
        .clk(clk), .rst_n(rst_n), .xfer_go_i(xfer_go), .int_time_i(int_time_i),
        .wr_en_i(wr_en_i), .ptr_q_i(ptr_q), .wr_data_i(wr_data_i), .user_o(user)
    );

    assign ptr_in_clk = ptr_q < CLK_END;

    // Read mux: host-copy byte, halt flag location, or zero.
    always_comb begin
        rd_data_o = '0;
        if (ptr_in_clk) begin
            for (int i = 0; i < N_CLK; i++)
                if (ptr_q[SEL_W-1:0] == SEL_W'(i)) rd_data_o = user[i*BYTE_W +: BYTE_W];
        end else if (ptr_q == HADDR) begin
            rd_data_o[HALT_BIT] = halt;
        end
    end

    // Forward host clock writes to the internal copy in the same cycle.
    assign int_wr_en_o   = wr_en_i && ptr_in_clk;
    assign int_wr_addr_o = ptr_q[SEL_W-1:0];
    assign int_wr_data_o = (ptr_q == '0) ? '0 : wr_data_i;

    assign ptr_o  = ptr_q;
    assign halt_o = halt;
    assign hold_o = hold;

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !wr_en_i) |=> $stable(user)); // R4
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !wr_en_i) |=> $stable(user)); // R7
    AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !ptr_load_i && !stop_i && ptr_q < CLK_END - 1'b1) |=> hold); // R4
endmodule

// File: tb/clk_snap_xfer_tb.sv
`timescale 1ns/1ps
module clk_snap_xfer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ptr_load_i, rd_en_i, wr_en_i, stop_i, pwr_fail_i, upd_tick_i;
    logic [4:0]  ptr_val_i;
    logic [7:0]  wr_data_i;
    logic [63:0] int_time_i;
    logic [7:0]  rd_data_o, int_wr_data_o;
    logic [4:0]  ptr_o;
    logic [2:0]  int_wr_addr_o;
    logic        halt_o, hold_o, int_wr_en_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    clk_snap_xfer u_dut (
        .clk(clk), .rst_n(rst_n), .ptr_load_i(ptr_load_i), .ptr_val_i(ptr_val_i),
        .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .stop_i(stop_i),
        .pwr_fail_i(pwr_fail_i), .upd_tick_i(upd_tick_i), .int_time_i(int_time_i),
        .rd_data_o(rd_data_o), .ptr_o(ptr_o), .halt_o(halt_o), .hold_o(hold_o),
        .int_wr_en_o(int_wr_en_o), .int_wr_addr_o(int_wr_addr_o), .int_wr_data_o(int_wr_data_o)
    );

    function automatic logic [7:0] pat(int s, int k);
        return 8'((s * 37 + k * 11 + 5) & 255);
    endfunction

    function automatic logic [63:0] pat_vec(int s);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = pat(s, k);
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic peek(int a, output logic [7:0] d);
        ptr_load_i = 1'b1; ptr_val_i = 5'(a);
        step();
        ptr_load_i = 1'b0;
        #0 d = rd_data_o;
    endtask

    task automatic do_tick(int s);
        int_time_i = pat_vec(s); upd_tick_i = 1'b1;
        step();
        upd_tick_i = 1'b0;
    endtask

    task automatic peek_all(string req, int s);
        logic [7:0] d;
        for (int k = 0; k < 8; k++) begin
            peek(k, d);
            chk(req, d, pat(s, k));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; ptr_load_i = 0; rd_en_i = 0; wr_en_i = 0; stop_i = 0;
        pwr_fail_i = 0; upd_tick_i = 0; ptr_val_i = '0; wr_data_i = '0; int_time_i = '0;
        repeat (3) step();
        // R1 reset state
        chk("R1 ptr", ptr_o, 0);
        chk("R1 halt", halt_o, 0);
        chk("R1 hold", hold_o, 0);
        chk("R1 data", rd_data_o, 0);
        rst_n = 1'b1;
        step();
        for (int k = 0; k < 8; k++) begin
            peek(k, d);
            chk("R1 byte", d, 0);
        end

        // R2 pointer sweep over two full wraps
        peek(0, d);
        for (int i = 0; i < 42; i++) begin
            rd_en_i = 1'b1; step(); rd_en_i = 1'b0;
            chk("R2 step", ptr_o, (i + 1) % 20);
        end
        peek(25, d);
        chk("R2 clamp", ptr_o, 0);
        peek(19, d);
        chk("R2 load", ptr_o, 19);
        stop_i = 1'b1; step(); stop_i = 1'b0;

        // R3 unblocked copies
        for (int s = 1; s <= 3; s++) begin
            do_tick(s);
            peek_all("R3 copy", s);
        end

        // R4 / R5 / R6 hold sweep from every clock address
        for (int a = 0; a < 8; a++) begin
            do_tick(10 + a);
            peek(a, d);
            rd_en_i = 1'b1; step(); rd_en_i = 1'b0;
            chk("R4 hold set", hold_o, (a < 7) ? 1 : 0);
            if (a < 7) begin
                do_tick(30 + a);
                peek_all("R4 frozen", 10 + a);
                chk("R4 hold kept", hold_o, 1);
                if (a % 2 == 0) begin
                    stop_i = 1'b1; step(); stop_i = 1'b0;
                    chk("R5 stop clears", hold_o, 0);
                    step();
                    peek_all("R5 pending copy", 30 + a);
                end else begin
                    peek(a + 1, d);
                    while (ptr_o < 8) begin
                        rd_en_i = 1'b1; step(); rd_en_i = 1'b0;
                    end
                    chk("R6 leave clears", hold_o, 0);
                    step();
                    peek_all("R6 pending copy", 30 + a);
                end
            end else begin
                // R6 read of 07h moves pointer to 08h and releases at once
                do_tick(30 + a);
                peek_all("R6 read last", 30 + a);
            end
        end

        // R7 power fail freezes
        do_tick(50);
        pwr_fail_i = 1'b1; step(); pwr_fail_i = 1'b0;
        chk("R7 halt set", halt_o, 1);
        do_tick(51);
        peek_all("R7 frozen", 50);
        peek(12, d);
        chk("R7 halt read", d, 8'h40);

        // R8 clearing the halt flag
        pwr_fail_i = 1'b1;
        peek(12, d);
        wr_en_i = 1'b1; wr_data_i = 8'h00; step(); wr_en_i = 1'b0;
        chk("R8 pf wins", halt_o, 1);
        pwr_fail_i = 1'b0;
        peek(12, d);
        wr_en_i = 1'b1; wr_data_i = 8'h00; step(); wr_en_i = 1'b0;
        chk("R8 cleared", halt_o, 0);
        step();
        peek_all("R8 resume", 51);
        peek(12, d);
        chk("R8 halt read", d, 0);

        // R9 host writes to every clock byte
        for (int a = 0; a < 8; a++) begin
            logic [7:0] wd;
            wd = 8'(8'hA1 + a * 29);
            peek(a, d);
            wr_en_i = 1'b1; wr_data_i = wd;
            #1;
            chk("R9 int en", int_wr_en_o, 1);
            chk("R9 int addr", int_wr_addr_o, a);
            chk("R9 int data", int_wr_data_o, (a == 0) ? 0 : wd);
            step(); wr_en_i = 1'b0;
            peek(a, d);
            chk("R9 stored", d, (a == 0) ? 0 : wd);
        end
        peek(9, d);
        wr_en_i = 1'b1; wr_data_i = 8'h55; #1;
        chk("R9 non-clock", int_wr_en_o, 0);
        step(); wr_en_i = 1'b0;

        // R10 non-clock reads
        peek(9, d);
        chk("R10 addr 9", d, 0);
        peek(19, d);
        chk("R10 addr 19", d, 0);
        peek(8, d);
        chk("R10 addr 8", d, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule